// File: doc/BRIEF.md
# Refresh Pacer with Postponement Credits

This block paces auto-refresh work for an SDRAM controller. A free-running phase counter marks the end of each nominal refresh interval. The interval length is the retention period in clock cycles divided by the number of refresh commands needed per retention period. Each interval end adds one credit to a small pending counter. Each acknowledge from the command sequencer takes one credit away. This lets the sequencer postpone refreshes while traffic is heavy, up to a hard ceiling of eight owed refreshes. At that ceiling an urgent request is raised, and the sequencer must not defer it.

The same phase counter drives a write gate. A new write burst may begin only while the cycles left in the current interval exceed the burst's worst-case duration, so a burst never runs across a refresh deadline. The controller ANDs `wr_permit` with its own write enable. There is also a sweep mode, used while user traffic itself touches every row within the retention period. In that mode refresh requests are silenced and the credits are dropped. When the mode ends, the block owes a parameterised run of back-to-back refreshes. This run covers any misalignment between the sweep position and the DRAM's internal refresh row counter.

All pins are plain level control and status signals, with no data stream. `rfsh_ack` is a single-cycle pulse that the sequencer raises in the cycle it issues a refresh command.

Top module: `rfsh_pacer`

## Requirements
- R1: While reset is held and in the first cycle after it, `pend_cnt` is 0, `rfsh_req` and `rfsh_urgent` are low, and `wr_permit` is high whenever `burst_len` is below the interval length.
- R2: Outside sweep mode the interval phase advances once per clock. Every INTERVAL = RETENTION_CYC / REFS_PER_RET clock edges, `pend_cnt` rises by one, so the first credit appears at edge INTERVAL after reset.
- R3: Outside sweep mode, and with no urgent request or catch-up run active, `wr_permit` is high exactly when cycles_left > `burst_len`. Here cycles_left = INTERVAL − phase, and phase counts 0..INTERVAL−1 from reset. A `burst_len` equal to cycles_left gives `wr_permit` low.
- R4: Outside sweep mode, `rfsh_req` is high whenever `pend_cnt` is nonzero or a catch-up run still owes refreshes.
- R5: `pend_cnt` saturates at MAX_PEND (8). `rfsh_urgent` is high exactly while `pend_cnt` equals MAX_PEND, and `wr_permit` is low while `rfsh_urgent` is high.
- R6: An `rfsh_ack` seen while `pend_cnt` is nonzero and no catch-up run is active lowers `pend_cnt` by one. An ack seen with nothing owed is ignored, and `pend_cnt` stays 0.
- R7: When an ack and an interval end fall on the same edge and `pend_cnt` is nonzero, `pend_cnt` is unchanged.
- R8: While `sweep_mode` is high, `rfsh_req` is low, `pend_cnt` is cleared to 0 at the next edge, the phase is held at 0, acks are ignored, and `wr_permit` is high.
- R9: On the first edge after `sweep_mode` falls, a catch-up run of CATCHUP refreshes is loaded. `rfsh_req` stays high and `wr_permit` stays low until CATCHUP acks have retired the run. These acks do not change `pend_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_len | input | BL_W | Worst-case duration of the next write burst, in clock cycles |
| rfsh_ack | input | 1 | Single-cycle pulse: sequencer issued one refresh command |
| sweep_mode | input | 1 | High while user traffic covers every row within retention |
| rfsh_req | output | 1 | At least one refresh is owed |
| rfsh_urgent | output | 1 | Postponement ceiling reached; refresh must issue now |
| wr_permit | output | 1 | A write burst of `burst_len` cycles may start |
| pend_cnt | output | PEND_W | Number of postponed refreshes currently owed |

## Verification
`pend_cnt`, and with it `rfsh_req` and `rfsh_urgent`, changes on the clock edge that ends an interval or that samples an ack. Each of these outputs is therefore due one edge after its cause. `wr_permit` follows `burst_len` in the same cycle but follows the phase counter one edge late. The catch-up run and the sweep clear both take effect one edge after `sweep_mode` changes. The bench drives every input at a falling edge. It counts the rising edges since reset release to know the exact phase and credit count, and it samples shortly after the edge that is due to have produced each result.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Operation applied to the postponement credit counter in one cycle.
  typedef enum logic [1:0] {
    CR_HOLD = 2'd0,
    CR_ADD  = 2'd1,
    CR_SUB  = 2'd2,
    CR_CLR  = 2'd3
  } credit_op_e;

  // Default ceiling on postponed refreshes.
  localparam int DEF_MAX_PEND = 8;

  // Wider of two widths, used to align comparison operands.
  function automatic int wider(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL = 976,
  parameter int CNT_W    = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,        // sweep mode: phase parked at zero
  output logic             tick,        // last cycle of the interval
  output logic [CNT_W:0]   cycles_left  // INTERVAL - phase
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] phase_q;

  assign tick        = !hold && (phase_q == LAST);
  assign cycles_left = (CNT_W + 1)'(INTERVAL) - {1'b0, phase_q};

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      phase_q <= '0;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + CNT_W'(1);
    end
  end

  // R2: the phase never leaves its interval and wraps after a tick.
  p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cycles_left != '0 && cycles_left <= (CNT_W + 1)'(INTERVAL));

  p_wrap_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cycles_left == (CNT_W + 1)'(INTERVAL));

endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit
  import rfsh_pkg::*;
#(
  parameter int MAX_PEND = DEF_MAX_PEND,
  parameter int PW       = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,   // sweep mode drops all credits
  input  logic          tick,    // interval end
  input  logic          take,    // qualified acknowledge
  output logic [PW-1:0] pend,
  output logic          full
);

  localparam logic [PW-1:0] CEIL = PW'(MAX_PEND);

  logic [PW-1:0] pend_q;
  credit_op_e    op;

  always_comb begin
    op = CR_HOLD;
    if (clear) begin
      op = CR_CLR;
    end else if (tick && take) begin
      // A paired ack and expiry cancel; with nothing owed the ack is void.
      op = (pend_q == '0) ? CR_ADD : CR_HOLD;
    end else if (tick) begin
      op = (pend_q == CEIL) ? CR_HOLD : CR_ADD;
    end else if (take) begin
      op = (pend_q == '0) ? CR_HOLD : CR_SUB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      unique case (op)
        CR_CLR:  pend_q <= '0;
        CR_ADD:  pend_q <= pend_q + PW'(1);
        CR_SUB:  pend_q <= pend_q - PW'(1);
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign pend = pend_q;
  assign full = (pend_q == CEIL);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= CEIL);

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0 && take && !tick && !clear) |=> pend_q == '0);

  p_pair_cancels_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0 && take && tick && !clear) |=> $stable(pend_q));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> pend_q == '0);

endmodule

// File: rtl/rfsh_catchup.sv
module rfsh_catchup #(
  parameter int CATCHUP = 8192,
  parameter int CU_W    = $clog2(CATCHUP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sweep,
  input  logic ack,
  output logic active
);

  logic            sweep_q;
  logic [CU_W-1:0] owed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sweep_q <= 1'b0;
      owed_q  <= '0;
    end else begin
      sweep_q <= sweep;
      if (sweep) begin
        owed_q <= '0;
      end else if (sweep_q) begin
        owed_q <= CU_W'(CATCHUP);
      end else if (ack && owed_q != '0) begin
        owed_q <= owed_q - CU_W'(1);
      end
    end
  end

  assign active = (owed_q != '0);

  p_drain_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ack && !sweep && !sweep_q) |=> owed_q == $past(owed_q) - CU_W'(1));

  p_idle_in_sweep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep && $past(sweep)) |-> !active);

endmodule

// File: rtl/rfsh_write_gate.sv
module rfsh_write_gate
  import rfsh_pkg::*;
#(
  parameter int LW   = 8,
  parameter int BL_W = 8
) (
  input  logic            sweep,
  input  logic            urgent,
  input  logic            catching_up,
  input  logic [LW-1:0]   cycles_left,
  input  logic [BL_W-1:0] burst_len,
  output logic            permit
);

  localparam int CW = wider(LW, BL_W);

  logic [CW-1:0] left_x;
  logic [CW-1:0] burst_x;
  logic          fits;

  assign left_x  = CW'(cycles_left);
  assign burst_x = CW'(burst_len);
  assign fits    = left_x > burst_x;

  always_comb begin
    if (sweep) begin
      permit = 1'b1;
    end else if (urgent || catching_up) begin
      permit = 1'b0;
    end else begin
      permit = fits;
    end
  end

endmodule

// File: rtl/rfsh_pacer.sv
module rfsh_pacer
  import rfsh_pkg::*;
#(
  parameter int RETENTION_CYC = 8000000,
  parameter int REFS_PER_RET  = 8192,
  parameter int MAX_PEND      = DEF_MAX_PEND,
  parameter int CATCHUP       = REFS_PER_RET,
  parameter int BL_W          = 8,
  parameter int PEND_W        = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BL_W-1:0]   burst_len,
  input  logic              rfsh_ack,
  input  logic              sweep_mode,
  output logic              rfsh_req,
  output logic              rfsh_urgent,
  output logic              wr_permit,
  output logic [PEND_W-1:0] pend_cnt
);

  localparam int INTERVAL = RETENTION_CYC / REFS_PER_RET;
  localparam int CNT_W    = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic             tick;
  logic [CNT_W:0]   cycles_left;
  logic             catch_active;
  logic             credit_take;
  logic             ack_live;
  logic             full;
  logic [PEND_W-1:0] pend;

  assign ack_live    = rfsh_ack && !sweep_mode;
  assign credit_take = ack_live && !catch_active;

  rfsh_interval_timer #(.INTERVAL(INTERVAL), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold(sweep_mode),
    .tick(tick), .cycles_left(cycles_left)
  );

  rfsh_credit #(.MAX_PEND(MAX_PEND), .PW(PEND_W)) u_credit (
    .clk(clk), .rst_n(rst_n), .clear(sweep_mode), .tick(tick),
    .take(credit_take), .pend(pend), .full(full)
  );

  rfsh_catchup #(.CATCHUP(CATCHUP)) u_catch (
    .clk(clk), .rst_n(rst_n), .sweep(sweep_mode), .ack(ack_live),
    .active(catch_active)
  );

  rfsh_write_gate #(.LW(CNT_W + 1), .BL_W(BL_W)) u_gate (
    .sweep(sweep_mode), .urgent(full), .catching_up(catch_active),
    .cycles_left(cycles_left), .burst_len(burst_len), .permit(wr_permit)
  );

  assign pend_cnt    = pend;
  assign rfsh_urgent = full && !sweep_mode;
  assign rfsh_req    = !sweep_mode && (pend != '0 || catch_active);

  p_urgent_implies_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_urgent |-> rfsh_req);

  p_urgent_blocks_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_urgent |-> !wr_permit);

  p_sweep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_mode |-> (!rfsh_req && wr_permit));

  p_catchup_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sweep_mode) |=> rfsh_req);

endmodule

// File: tb/sim_rfsh_pacer.sv
module sim_rfsh_pacer;

  localparam int RET   = 400;
  localparam int REFS  = 8;
  localparam int IVL   = RET / REFS;   // 50
  localparam int CATCH = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] burst_len;
  logic       rfsh_ack;
  logic       sweep_mode;
  logic       rfsh_req;
  logic       rfsh_urgent;
  logic       wr_permit;
  logic [3:0] pend_cnt;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;   // 125 MHz

  rfsh_pacer #(.RETENTION_CYC(RET), .REFS_PER_RET(REFS), .CATCHUP(CATCH)) u0 (
    .clk(clk), .rst_n(rst_n), .burst_len(burst_len), .rfsh_ack(rfsh_ack),
    .sweep_mode(sweep_mode), .rfsh_req(rfsh_req), .rfsh_urgent(rfsh_urgent),
    .wr_permit(wr_permit), .pend_cnt(pend_cnt)
  );

  // [31:16] edges after reset, [15:8] burst_len, [7] permit, [6] req,
  // [5] urgent, [4] pad, [3:0] pend_cnt
  localparam logic [31:0] VEC [0:8] = '{
    {16'd0,   8'd10, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0},  // R1 R3
    {16'd39,  8'd10, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0},  // R3 left 11
    {16'd40,  8'd10, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0},  // R3 left 10
    {16'd49,  8'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd0},  // R3 left 1
    {16'd50,  8'd10, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1},  // R2 R4
    {16'd100, 8'd60, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 R3
    {16'd399, 8'd0,  1'b1, 1'b1, 1'b0, 1'b0, 4'd7},  // R3 R5
    {16'd400, 8'd10, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8},  // R5
    {16'd470, 8'd10, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8}   // R5 saturation
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] bl);
    @(negedge clk);
    rst_n = 1'b0; rfsh_ack = 1'b0; sweep_mode = 1'b0; burst_len = bl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_ack;
    @(negedge clk); rfsh_ack = 1'b1;
    @(negedge clk); rfsh_ack = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rfsh_ack = 1'b0; sweep_mode = 1'b0; burst_len = 8'd10;

    // R1: values while reset is held
    repeat (2) @(posedge clk); #2;
    chk("R1 req in reset", rfsh_req, 0);
    chk("R1 pend in reset", pend_cnt, 0);
    chk("R1 permit in reset", wr_permit, 1);

    for (int i = 0; i < 9; i++) begin
      do_reset(VEC[i][15:8]);
      if (VEC[i][31:16] == 16'd0) #2;
      else edges(int'(VEC[i][31:16]));
      chk($sformatf("R3 vec%0d permit", i), wr_permit, int'(VEC[i][7]));
      chk($sformatf("R4 vec%0d req", i), rfsh_req, int'(VEC[i][6]));
      chk($sformatf("R5 vec%0d urgent", i), rfsh_urgent, int'(VEC[i][5]));
      chk($sformatf("R2 vec%0d pend", i), pend_cnt, int'(VEC[i][3:0]));
    end

    // R6: ack from the ceiling drops one credit and clears urgency
    pulse_ack; #2;
    chk("R6 pend after ack", pend_cnt, 7);
    chk("R6 urgent after ack", rfsh_urgent, 0);

    // R6: ack with nothing owed is ignored
    do_reset(8'd10);
    edges(5);
    pulse_ack; #2;
    chk("R6 ack at zero pend", pend_cnt, 0);
    chk("R6 ack at zero req", rfsh_req, 0);

    // R7: ack on the same edge as an interval end
    do_reset(8'd10);
    edges(99);
    chk("R7 pend before pair", pend_cnt, 1);
    pulse_ack; #2;
    chk("R7 pend after pair", pend_cnt, 1);

    // R8: sweep clears credits and silences requests
    do_reset(8'd10);
    edges(120);
    @(negedge clk); sweep_mode = 1'b1;
    edges(1);
    chk("R8 pend cleared", pend_cnt, 0);
    chk("R8 req silent", rfsh_req, 0);
    edges(200);
    pulse_ack; #2;
    chk("R8 pend held in sweep", pend_cnt, 0);
    chk("R8 permit in sweep", wr_permit, 1);

    // R9: catch-up run after sweep ends
    @(negedge clk); sweep_mode = 1'b0;
    edges(1);
    chk("R9 req after sweep", rfsh_req, 1);
    chk("R9 permit blocked", wr_permit, 0);
    for (int k = 0; k < CATCH - 1; k++) pulse_ack;
    #2;
    chk("R9 req before last ack", rfsh_req, 1);
    chk("R9 pend untouched", pend_cnt, 0);
    pulse_ack; #2;
    chk("R9 req after run", rfsh_req, 0);
    chk("R9 permit restored", wr_permit, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule